// File: doc/BRIEF.md
# Table Pointer Write Buffer

This block sits between the CPU and the program-memory write latches. Software loads a 24-bit table pointer one byte at a time and then issues single-byte table commands. A table read fetches the byte the pointer addresses from a memory model into an 8-bit data latch. A table write copies the latch into one of a parameterised bank of holding registers. The pointer's low bits select that register. Each command can leave the pointer alone, step it after the access, or step it before the access.

Table writes never touch memory. When the commit strobe arrives, the block takes a snapshot of the holding registers and of the row base address. The row base is the pointer with its block-offset bits cleared. The block presents both for one cycle and then refills the bank with the erased value FFh. The row is chosen from the pointer at commit time. Software must therefore leave the pointer inside the block it filled, for example by stepping back once after a run of post-increment writes.

Top module: `tpw_buffer`

## Requirements
- R1: After reset, `ptr_q` is 000000h, `lat_q` is 00h, `row_valid` is 0 and every holding register holds FFh.
- R2: With `ptr_wr_en` high, `ptr_wr_sel` chooses the byte of the pointer that takes `ptr_wr_data`: 0 loads bits 7:0, 1 loads bits 15:8 and 2 loads bits 23:16. The other bytes keep their value. Select value 3 leaves the pointer unchanged.
- R3: In `cmd_mode` 0 (plain), a command accesses the byte at the pointer and the pointer does not change. A read places `mem_rdata` for `mem_addr` equal to the pointer into `lat_q` on the next edge.
- R4: In `cmd_mode` 1 (post-increment), a command accesses the byte at the pointer, and the pointer then becomes pointer+1 modulo 2^24.
- R5: In `cmd_mode` 2 (post-decrement), a command accesses the byte at the pointer, and the pointer then becomes pointer-1 modulo 2^24. From 000000h it wraps to FFFFFFh.
- R6: In `cmd_mode` 3 (pre-increment), the pointer becomes pointer+1 and the access uses that new address. `mem_addr` shows pointer+1 during the command.
- R7: A write command (`cmd_write` = 1) stores `lat_q` into holding register number (access address modulo BLK_BYTES). A write changes neither `lat_q` nor memory.
- R8: A commit makes `row_valid` high in the next cycle, and for that cycle only unless commit stays high. In that cycle `row_base` equals the pointer at commit with its low log2(BLK_BYTES) bits cleared. Byte i of `row_data` (bits 8i+7:8i) equals holding register i.
- R9: After a commit, every holding register reads FFh, so the next commit shows FFh in every byte that was not written.
- R10: `lat_wr_en` loads `lat_wr_data` into `lat_q`. A table read accepted in the same cycle takes precedence.
- R11: A commit takes precedence: a pointer load and a table command in the same cycle are ignored. A pointer load takes precedence over a table command in the same cycle, which is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr_en | input | 1 | Load one pointer byte |
| ptr_wr_sel | input | 2 | Pointer byte select (0 low, 1 high, 2 upper) |
| ptr_wr_data | input | 8 | Pointer byte value |
| lat_wr_en | input | 1 | Load the data latch from software |
| lat_wr_data | input | 8 | Data latch value |
| cmd_valid | input | 1 | Issue a table command |
| cmd_write | input | 1 | 1 for table write, 0 for table read |
| cmd_mode | input | 2 | 0 plain, 1 post-increment, 2 post-decrement, 3 pre-increment |
| commit | input | 1 | Snapshot the row and clear the holding registers |
| mem_addr | output | 24 | Access address for the memory model |
| mem_rdata | input | 8 | Memory byte at `mem_addr` |
| ptr_q | output | 24 | Current table pointer |
| lat_q | output | 8 | Data latch |
| row_valid | output | 1 | Row snapshot valid |
| row_base | output | 24 | Row base address |
| row_data | output | 8*BLK_BYTES | Holding-register snapshot, byte i at bits 8i+7:8i |

## Verification
The assertions assume that `mem_rdata` is a function of `mem_addr` settled within the cycle. They also assume that `cmd_mode` and `cmd_write` are stable while `cmd_valid` is high. The bench meets both by driving every input at the falling edge and by computing `mem_rdata` combinationally from `mem_addr` with a fixed arithmetic mix. The bench then sweeps every access mode over reads and writes across all holding-register indices of an 8-byte configuration. It drives same-cycle collisions of commit, pointer load, latch load and commands on purpose, so the precedence rules are covered.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  localparam int PTR_W = 24;

  typedef enum logic [1:0] {
    ACC_PLAIN   = 2'd0,
    ACC_POSTINC = 2'd1,
    ACC_POSTDEC = 2'd2,
    ACC_PREINC  = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_NONE  = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/tpw_pointer.sv
module tpw_pointer
  import tpw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  ptr_sel_e         load_sel,
  input  logic [7:0]       load_data,
  input  logic             step_en,
  input  acc_mode_e        mode,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] acc_addr
);
  logic [PTR_W-1:0] ptr_r;
  logic [PTR_W-1:0] ptr_nxt;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;
  logic             ptr_en;

  assign ptr_inc = ptr_r + PTR_W'(1);
  assign ptr_dec = ptr_r - PTR_W'(1);

  always_comb begin
    ptr_nxt = ptr_r;
    ptr_en  = 1'b0;
    if (load_en) begin
      ptr_en = 1'b1;
      case (load_sel)
        SEL_LOW:   ptr_nxt[7:0]   = load_data;
        SEL_HIGH:  ptr_nxt[15:8]  = load_data;
        SEL_UPPER: ptr_nxt[23:16] = load_data;
        default:   ptr_en         = 1'b0;
      endcase
    end else if (step_en) begin
      ptr_en = 1'b1;
      case (mode)
        ACC_POSTINC, ACC_PREINC: ptr_nxt = ptr_inc;
        ACC_POSTDEC:             ptr_nxt = ptr_dec;
        default:                 ptr_en  = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_r <= '0;
    end else if (ptr_en) begin
      ptr_r <= ptr_nxt;
    end
  end

  assign ptr_q    = ptr_r;
  assign acc_addr = (mode == ACC_PREINC) ? ptr_inc : ptr_r;
endmodule

// File: rtl/tpw_hold_bank.sv
module tpw_hold_bank #(
  parameter int BLK_BYTES = 16,
  localparam int IDX_W    = $clog2(BLK_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_data,
  input  logic                   clear,
  output logic [BLK_BYTES*8-1:0] bank_q
);
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_byte
    logic [7:0] byte_r;
    logic [7:0] byte_nxt;
    logic       byte_en;

    always_comb begin
      byte_nxt = byte_r;
      byte_en  = 1'b0;
      if (clear) begin
        byte_nxt = 8'hFF;
        byte_en  = 1'b1;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        byte_nxt = wr_data;
        byte_en  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_r <= 8'hFF;
      end else if (byte_en) begin
        byte_r <= byte_nxt;
      end
    end

    assign bank_q[g*8 +: 8] = byte_r;
  end
endmodule

// File: rtl/tpw_buffer.sv
module tpw_buffer
  import tpw_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ptr_wr_en,
  input  logic [1:0]             ptr_wr_sel,
  input  logic [7:0]             ptr_wr_data,
  input  logic                   lat_wr_en,
  input  logic [7:0]             lat_wr_data,
  input  logic                   cmd_valid,
  input  logic                   cmd_write,
  input  logic [1:0]             cmd_mode,
  input  logic                   commit,
  output logic [23:0]            mem_addr,
  input  logic [7:0]             mem_rdata,
  output logic [23:0]            ptr_q,
  output logic [7:0]             lat_q,
  output logic                   row_valid,
  output logic [23:0]            row_base,
  output logic [BLK_BYTES*8-1:0] row_data
);
  localparam int IDX_W = $clog2(BLK_BYTES);

  logic                   ptr_load;
  logic                   cmd_go;
  logic                   rd_go;
  logic                   wr_go;
  logic [PTR_W-1:0]       acc_addr;
  logic [BLK_BYTES*8-1:0] bank_q;
  logic [7:0]             lat_r;
  logic [7:0]             lat_nxt;
  logic                   lat_en;
  logic                   rv_r;
  logic [PTR_W-1:0]       rb_r;
  logic [BLK_BYTES*8-1:0] rd_r;

  assign ptr_load = ptr_wr_en & ~commit;
  assign cmd_go   = cmd_valid & ~commit & ~ptr_wr_en;
  assign rd_go    = cmd_go & ~cmd_write;
  assign wr_go    = cmd_go & cmd_write;

  tpw_pointer u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (ptr_load),
    .load_sel  (ptr_sel_e'(ptr_wr_sel)),
    .load_data (ptr_wr_data),
    .step_en   (cmd_go),
    .mode      (acc_mode_e'(cmd_mode)),
    .ptr_q     (ptr_q),
    .acc_addr  (acc_addr)
  );

  tpw_hold_bank #(.BLK_BYTES(BLK_BYTES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_go),
    .wr_idx  (acc_addr[IDX_W-1:0]),
    .wr_data (lat_r),
    .clear   (commit),
    .bank_q  (bank_q)
  );

  always_comb begin
    lat_nxt = lat_r;
    lat_en  = 1'b0;
    if (rd_go) begin
      lat_nxt = mem_rdata;
      lat_en  = 1'b1;
    end else if (lat_wr_en) begin
      lat_nxt = lat_wr_data;
      lat_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_r <= '0;
    end else if (lat_en) begin
      lat_r <= lat_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_r <= 1'b0;
    end else begin
      rv_r <= commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_r <= '0;
      rd_r <= '0;
    end else if (commit) begin
      rb_r <= {ptr_q[PTR_W-1:IDX_W], {IDX_W{1'b0}}};
      rd_r <= bank_q;
    end
  end

  assign mem_addr  = acc_addr;
  assign lat_q     = lat_r;
  assign row_valid = rv_r;
  assign row_base  = rb_r;
  assign row_data  = rd_r;
endmodule

// File: rtl/tpw_buffer_chk.sv
module tpw_buffer_chk #(
  parameter int BLK_BYTES = 16,
  localparam int IDX_W    = $clog2(BLK_BYTES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ptr_wr_en,
  input logic                   cmd_valid,
  input logic                   cmd_write,
  input logic [1:0]             cmd_mode,
  input logic                   commit,
  input logic [23:0]            mem_addr,
  input logic [7:0]             mem_rdata,
  input logic [23:0]            ptr_q,
  input logic [7:0]             lat_q,
  input logic                   row_valid,
  input logic [23:0]            row_base
);
  logic go;
  assign go = cmd_valid && !commit && !ptr_wr_en;

  AST_IDLE_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr_en && !cmd_valid) |=> $stable(ptr_q)); // R2

  AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cmd_write) |=> (lat_q == $past(mem_rdata))); // R3

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_mode == 2'd1) |=> (ptr_q == $past(ptr_q) + 24'd1)); // R4

  AST_POSTDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_mode == 2'd2) |=> (ptr_q == $past(ptr_q) - 24'd1)); // R5

  AST_PREINC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_mode == 2'd3) |-> (mem_addr == ptr_q + 24'd1)); // R6

  AST_WRITE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_write) |=> $stable(lat_q)); // R7

  AST_ROW_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> row_valid); // R8

  AST_ROW_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> !row_valid); // R8

  AST_ROW_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> (row_base[IDX_W-1:0] == '0)); // R8

  AST_COMMIT_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> $stable(ptr_q)); // R11
endmodule

bind tpw_buffer tpw_buffer_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ptr_wr_en (ptr_wr_en),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .cmd_mode  (cmd_mode),
  .commit    (commit),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .ptr_q     (ptr_q),
  .lat_q     (lat_q),
  .row_valid (row_valid),
  .row_base  (row_base)
);

// File: tb/tpw_buffer_tb.sv
module tpw_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLK        = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ptr_wr_en = 1'b0;
  logic [1:0]    ptr_wr_sel = 2'd0;
  logic [7:0]    ptr_wr_data = 8'd0;
  logic          lat_wr_en = 1'b0;
  logic [7:0]    lat_wr_data = 8'd0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [1:0]    cmd_mode = 2'd0;
  logic          commit = 1'b0;
  logic [23:0]   mem_addr;
  logic [7:0]    mem_rdata;
  logic [23:0]   ptr_q;
  logic [7:0]    lat_q;
  logic          row_valid;
  logic [23:0]   row_base;
  logic [BLK*8-1:0] row_data;

  int n_chk = 0;
  int n_err = 0;

  logic [23:0] ref_ptr;
  logic [7:0]  ref_lat;
  logic [7:0]  ref_hold [BLK];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  tpw_buffer #(.BLK_BYTES(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
    .ptr_wr_data(ptr_wr_data), .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_mode(cmd_mode),
    .commit(commit), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ptr_q(ptr_q),
    .lat_q(lat_q), .row_valid(row_valid), .row_base(row_base), .row_data(row_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [BLK*8-1:0] pack_hold();
    logic [BLK*8-1:0] v;
    for (int i = 0; i < BLK; i++) v[i*8 +: 8] = ref_hold[i];
    return v;
  endfunction

  task automatic load_ptr(input logic [23:0] v);
    ptr_wr_en = 1'b1;
    ptr_wr_sel = 2'd2; ptr_wr_data = v[23:16]; step();
    ptr_wr_sel = 2'd1; ptr_wr_data = v[15:8];  step();
    ptr_wr_sel = 2'd0; ptr_wr_data = v[7:0];   step();
    ptr_wr_en = 1'b0;
    ref_ptr = v;
  endtask

  task automatic set_lat(input logic [7:0] v);
    lat_wr_en = 1'b1; lat_wr_data = v; step(); lat_wr_en = 1'b0;
    ref_lat = v;
  endtask

  task automatic do_cmd(input logic wr, input logic [1:0] m);
    logic [23:0] eff;
    string tag;
    eff = (m == 2'd3) ? ref_ptr + 24'd1 : ref_ptr;
    cmd_valid = 1'b1; cmd_write = wr; cmd_mode = m;
    step();
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_mode = 2'd0;
    if (wr) ref_hold[eff[2:0]] = ref_lat;
    else    ref_lat = mem_f(eff);
    case (m)
      2'd1: begin ref_ptr = ref_ptr + 24'd1; tag = "R4 post-increment"; end
      2'd2: begin ref_ptr = ref_ptr - 24'd1; tag = "R5 post-decrement"; end
      2'd3: begin ref_ptr = ref_ptr + 24'd1; tag = "R6 pre-increment"; end
      default: tag = "R3 plain";
    endcase
    chk({tag, " pointer"}, 64'(ptr_q), 64'(ref_ptr));
    chk(wr ? "R7 write keeps latch" : {tag, " read latch"}, 64'(lat_q), 64'(ref_lat));
  endtask

  task automatic do_commit();
    commit = 1'b1; step(); commit = 1'b0;
    chk("R8 row_valid after commit", 64'(row_valid), 64'd1);
    chk("R8 row_base", 64'(row_base), 64'({ref_ptr[23:3], 3'b000}));
    chk("R8 R7 row_data", 64'(row_data), 64'(pack_hold()));
    for (int i = 0; i < BLK; i++) ref_hold[i] = 8'hFF;
    step();
    chk("R8 row_valid single cycle", 64'(row_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    ref_ptr = '0; ref_lat = '0;
    for (int i = 0; i < BLK; i++) ref_hold[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset pointer", 64'(ptr_q), 64'd0);
    chk("R1 reset latch", 64'(lat_q), 64'd0);
    chk("R1 reset row_valid", 64'(row_valid), 64'd0);
    rst_n = 1'b1;
    step();

    // R1: the bank starts erased
    do_commit();

    // R2: byte loads, then select 3 ignored
    load_ptr(24'h123456);
    chk("R2 pointer load", 64'(ptr_q), 64'h123456);
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd3; ptr_wr_data = 8'h99; step(); ptr_wr_en = 1'b0;
    chk("R2 select 3 ignored", 64'(ptr_q), 64'h123456);
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd1; ptr_wr_data = 8'hC3; step(); ptr_wr_en = 1'b0;
    chk("R2 high byte only", 64'(ptr_q), 64'h12C356);
    ref_ptr = 24'h12C356;

    // read sweep over every mode (R3 R4 R5 R6)
    for (int m = 0; m < 4; m++) begin
      load_ptr(24'h00ABF0 + 24'(m * 16));
      for (int k = 0; k < 6; k++) do_cmd(1'b0, 2'(m));
    end

    // wrap cases
    load_ptr(24'hFFFFFF); do_cmd(1'b0, 2'd1);
    chk("R4 wrap to zero", 64'(ptr_q), 64'd0);
    do_cmd(1'b0, 2'd2);
    chk("R5 wrap to FFFFFF", 64'(ptr_q), 64'hFFFFFF);
    do_cmd(1'b0, 2'd3);

    // fill every index with post-increment writes, step back, commit (R7 R8)
    load_ptr(24'h001230);
    for (int i = 0; i < BLK; i++) begin
      set_lat(8'(8'h30 + i * 7));
      do_cmd(1'b1, 2'd1);
    end
    do_cmd(1'b0, 2'd2);
    do_commit();
    // R9: nothing written since the last commit
    do_commit();

    // mixed modes on writes
    load_ptr(24'h001231);
    set_lat(8'hAA); do_cmd(1'b1, 2'd3);
    set_lat(8'hBB); do_cmd(1'b1, 2'd2);
    set_lat(8'hCC); do_cmd(1'b1, 2'd0);
    do_commit();

    // commit with a pointer that left the block selects the next row (R8)
    load_ptr(24'h00203E);
    set_lat(8'h11); do_cmd(1'b1, 2'd1);
    set_lat(8'h22); do_cmd(1'b1, 2'd1);
    do_commit();

    // R11: commit beats pointer load and write
    load_ptr(24'h004440);
    set_lat(8'h5A);
    commit = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'd1;
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 8'h77;
    step();
    commit = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; ptr_wr_en = 1'b0;
    chk("R11 commit blocks pointer change", 64'(ptr_q), 64'h004440);
    chk("R11 commit row data", 64'(row_data), 64'(pack_hold()));
    step();
    do_commit();

    // R11: pointer load beats read
    set_lat(8'h3C);
    cmd_valid = 1'b1; cmd_mode = 2'd1;
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 8'h44;
    step();
    cmd_valid = 1'b0; ptr_wr_en = 1'b0; cmd_mode = 2'd0;
    chk("R11 load wins pointer", 64'(ptr_q), 64'h004444);
    chk("R11 read dropped latch", 64'(lat_q), 64'h3C);
    ref_ptr = 24'h004444;

    // R10: read beats software latch load
    lat_wr_en = 1'b1; lat_wr_data = 8'h11; cmd_valid = 1'b1;
    step();
    lat_wr_en = 1'b0; cmd_valid = 1'b0;
    chk("R10 read wins latch", 64'(lat_q), 64'(mem_f(24'h004444)));
    set_lat(8'hE7);
    chk("R10 latch load", 64'(lat_q), 64'hE7);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule